// File: doc/BRIEF.md
# UART Byte Queue with Packed Status

This block is a synchronous byte queue that sits between a serial engine and a host bus. One side pushes bytes with a write strobe. The other side pulls them with a read strobe. The read data is registered, so a byte appears on `rd_data` in the cycle after the edge that accepted the strobe.

A 16-bit status word reports three things: the configured size, the current fill level, and two interrupt bits. The meaning of the interrupt bits depends on whether the instance is built for the receive path or the transmit path. A sticky error flag records misuse of the queue. A synchronous reset empties the queue; in receive use the surrounding logic drives this reset on a line break, a receiver reset or a system reset.

There is no back-pressure on either side, because both strobes are plain one-cycle commands. The producer must watch the status word before it writes; a write into a full queue is lost and flagged. The consumer must watch `not_empty` before it reads; a read from an empty queue returns nothing new and is flagged.

Top module: `uart_queue`

## Requirements
- R1: After reset, `not_empty` is 0, `err` is 0, `rd_data` is 0 and the fill level is 0.
- R2: Bytes leave in the order they were written. A read strobe accepted at a clock edge puts the oldest byte on `rd_data` right after that edge, and `rd_data` holds that byte until the next accepted read.
- R3: The queue holds at most 2^L-1 bytes, where L is the clamped log2 size. A write strobe without a read strobe while the queue is full is dropped, leaves the contents unchanged and sets `err`.
- R4: A read strobe without a write strobe while the queue is empty sets `err`, leaves the fill level at 0 and leaves `rd_data` unchanged.
- R5: Once set, `err` stays 1 until reset, whatever the strobes do.
- R6: A read strobe and a write strobe in the same cycle on an empty queue pass the written byte straight to `rd_data` after that edge. The fill level stays 0 and `err` is not set.
- R7: A read strobe and a write strobe in the same cycle on a full queue both take effect. The oldest byte appears on `rd_data`, the new byte joins the tail, the fill level stays full and `err` is not set.
- R8: `status[15:12]` holds L, `status[L+1:2]` holds the fill level, and any bits of `status[11:2]` above the fill field read 0.
- R9: In receive orientation (`RX_MODE`=1), `status[0]` is 1 when the fill level is nonzero, and `status[1]` is 1 when the fill level is at least 2^(L-1).
- R10: In transmit orientation (`RX_MODE`=0), `status[0]` is 1 when the fill level is below 2^L-1 (a slot is free), and `status[1]` is 1 when the fill level is below 2^(L-1).
- R11: L equals `LGFLEN` clamped to the range 2 to 10.
- R12: Asserting `rst` in the middle of operation empties the queue and clears `err` after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; empties the queue |
| wr_stb | input | 1 | Write command for one cycle |
| wr_data | input | DATA_W | Byte to write |
| rd_stb | input | 1 | Read command for one cycle |
| rd_data | output | DATA_W | Registered byte from the last accepted read |
| not_empty | output | 1 | At least one byte is held |
| status | output | 16 | Size, fill level and orientation-dependent interrupt bits |
| err | output | 1 | Sticky misuse flag (overfilled or over-read) |

## Verification
The main instance is a receive queue with `LGFLEN`=3. Its capacity of seven bytes makes it quick to fill, so the bench can reach the full-queue cases: the dropped write, the simultaneous read and write at capacity, and the half-full threshold at four bytes. A second instance is built in transmit orientation with `LGFLEN`=1. It checks that the value is raised to 2, and it walks the free-slot and below-half bits through every fill level of a three-byte queue. A third instance, with `LGFLEN`=12, shows that the upper clamp puts 10 into the size field.

// File: rtl/uq_pkg.sv
package uq_pkg;
  localparam int STATUS_W = 16;
  localparam int LG_MIN   = 2;
  localparam int LG_MAX   = 10;

  function automatic int lg_clamp(input int v);
    if (v < LG_MIN) return LG_MIN;
    if (v > LG_MAX) return LG_MAX;
    return v;
  endfunction
endpackage

// File: rtl/uq_ctrl.sv
module uq_ctrl #(
  parameter int LG = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic [LG-1:0] wr_ptr,
  output logic [LG-1:0] rd_ptr,
  output logic [LG-1:0] count,
  output logic          push,
  output logic          pop,
  output logic          bypass,
  output logic          err
);
  localparam logic [LG-1:0] CAP = '1;

  logic full, empty;

  always_comb begin
    full   = (count == CAP);
    empty  = (count == '0);
    bypass = wr_stb && rd_stb && empty;
    pop    = rd_stb && !empty;
    push   = wr_stb && !bypass && (!full || rd_stb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      err    <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if ((rd_stb && empty && !wr_stb) || (wr_stb && full && !rd_stb))
        err <= 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_stb && !rd_stb) |=> (full && err && $stable(wr_ptr)));

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_stb && !wr_stb) |=> (count == '0 && err && $stable(rd_ptr)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_full_both_R7: assert property (@(posedge clk) disable iff (rst)
    (full && wr_stb && rd_stb) |=> (count == CAP && $changed(rd_ptr)));

  assert_reset_empty_R12: assert property (@(posedge clk)
    rst |=> (count == '0 && !err));
endmodule

// File: rtl/uq_store.sv
module uq_store #(
  parameter int LG     = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              bypass,
  input  logic [LG-1:0]     wr_ptr,
  input  logic [LG-1:0]     rd_ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << LG;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (bypass) rd_data <= wr_data;
    else if (pop)    rd_data <= mem[rd_ptr];
  end

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (rd_data == $past(wr_data)));

  assert_hold_data_R4: assert property (@(posedge clk) disable iff (rst)
    (!pop && !bypass) |=> $stable(rd_data));
endmodule

// File: rtl/uq_status.sv
module uq_status #(
  parameter int LG      = 4,
  parameter bit RX_MODE = 1'b1
) (
  input  logic [LG-1:0]               count,
  output logic [uq_pkg::STATUS_W-1:0] status
);
  localparam logic [LG-1:0] CAP  = '1;
  localparam logic [LG-1:0] HALF = LG'(1 << (LG - 1));

  logic [1:0]  irq;
  logic [11:0] level;

  generate
    if (RX_MODE) begin : g_rx
      always_comb begin
        irq[0] = (count != '0);
        irq[1] = (count >= HALF);
      end
    end else begin : g_tx
      always_comb begin
        irq[0] = (count != CAP);
        irq[1] = (count < HALF);
      end
    end
  endgenerate

  always_comb begin
    level = '0;
    level[LG+1:2] = count;
    level[1:0]    = irq;
    status = {4'(LG), level};
  end
endmodule

// File: rtl/uart_queue.sv
module uart_queue #(
  parameter int LGFLEN  = 4,
  parameter int DATA_W  = 8,
  parameter bit RX_MODE = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_stb,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        rd_stb,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        not_empty,
  output logic [uq_pkg::STATUS_W-1:0] status,
  output logic                        err
);
  localparam int LG = uq_pkg::lg_clamp(LGFLEN);

  logic [LG-1:0] wr_ptr, rd_ptr, count;
  logic          push, pop, bypass;

  uq_ctrl #(.LG(LG)) u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .push(push), .pop(pop), .bypass(bypass), .err(err)
  );

  uq_store #(.LG(LG), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .bypass(bypass),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_data(wr_data), .rd_data(rd_data)
  );

  uq_status #(.LG(LG), .RX_MODE(RX_MODE)) u_status (
    .count(count), .status(status)
  );

  assign not_empty = (count != '0);

  assert_ne_tracks_level_R8: assert property (@(posedge clk) disable iff (rst)
    not_empty == (status[LG+1:2] != '0));
endmodule

// File: tb/uart_queue_tb.sv
module uart_queue_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // main instance: receive orientation, L=3, capacity 7
  logic wr_stb = 0, rd_stb = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic not_empty, err;
  logic [15:0] status;

  uart_queue #(.LGFLEN(3), .DATA_W(8), .RX_MODE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
    .rd_data(rd_data), .not_empty(not_empty), .status(status), .err(err)
  );

  // transmit orientation, LGFLEN=1 clamped to 2, capacity 3
  logic t_wr = 0, t_rd = 0;
  logic [7:0] t_wd = 0, t_rdata;
  logic t_ne, t_err;
  logic [15:0] t_status;

  uart_queue #(.LGFLEN(1), .DATA_W(8), .RX_MODE(1'b0)) u_tx (
    .clk(clk), .rst(rst), .wr_stb(t_wr), .wr_data(t_wd), .rd_stb(t_rd),
    .rd_data(t_rdata), .not_empty(t_ne), .status(t_status), .err(t_err)
  );

  // upper clamp instance, LGFLEN=12 -> 10
  logic [7:0] b_rdata;
  logic b_ne, b_err;
  logic [15:0] b_status;

  uart_queue #(.LGFLEN(12), .DATA_W(8), .RX_MODE(1'b1)) u_big (
    .clk(clk), .rst(rst), .wr_stb(1'b0), .wr_data(8'h00), .rd_stb(1'b0),
    .rd_data(b_rdata), .not_empty(b_ne), .status(b_status), .err(b_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected receive status for L=3 (R8, R9)
  function automatic logic [15:0] rx_st(input int f);
    return 16'h3000 | 16'(f << 2) | ((f >= 4) ? 16'h2 : 16'h0) | ((f != 0) ? 16'h1 : 16'h0);
  endfunction

  // expected transmit status for L=2 (R8, R10)
  function automatic logic [15:0] tx_st(input int f);
    return 16'h2000 | 16'(f << 2) | ((f < 2) ? 16'h2 : 16'h0) | ((f < 3) ? 16'h1 : 16'h0);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic op(input logic w, input logic [7:0] d, input logic r);
    wr_stb = w; wr_data = d; rd_stb = r;
    @(negedge clk);
    wr_stb = 0; rd_stb = 0;
  endtask

  task automatic top(input logic w, input logic [7:0] d, input logic r);
    t_wr = w; t_wd = d; t_rd = r;
    @(negedge clk);
    t_wr = 0; t_rd = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset_state();
    chk("R1 not_empty", 16'(not_empty), 16'h0);
    chk("R1 err", 16'(err), 16'h0);
    chk("R1 rd_data", 16'(rd_data), 16'h0);
    chk("R1 R9 status", status, rx_st(0));
  endtask

  task automatic t_order();
    op(1, 8'hA1, 0); op(1, 8'hB2, 0); op(1, 8'hC3, 0);
    chk("R8 fill3", status, rx_st(3));
    chk("R1 not_empty after writes", 16'(not_empty), 16'h1);
    op(0, 0, 1); chk("R2 first", 16'(rd_data), 16'hA1);
    @(negedge clk); chk("R2 hold", 16'(rd_data), 16'hA1);
    op(0, 0, 1); chk("R2 second", 16'(rd_data), 16'hB2);
    op(0, 0, 1); chk("R2 third", 16'(rd_data), 16'hC3);
    chk("R8 drained", status, rx_st(0));
  endtask

  task automatic t_bypass();
    op(1, 8'h5A, 1);
    chk("R6 data", 16'(rd_data), 16'h5A);
    chk("R6 status", status, rx_st(0));
    chk("R6 err", 16'(err), 16'h0);
  endtask

  task automatic t_full_both();
    for (int i = 0; i < 7; i++) begin
      op(1, 8'(8'h20 + i), 0);
      chk("R9 fill status", status, rx_st(i + 1));
    end
    op(1, 8'h77, 1);
    chk("R7 oldest out", 16'(rd_data), 16'h20);
    chk("R7 still full", status, rx_st(7));
    chk("R7 err", 16'(err), 16'h0);
    for (int i = 1; i < 7; i++) begin
      op(0, 0, 1);
      chk("R7 drain", 16'(rd_data), 16'(8'h20 + i));
    end
    op(0, 0, 1);
    chk("R7 tail byte", 16'(rd_data), 16'h77);
    chk("R7 empty", status, rx_st(0));
  endtask

  task automatic t_full_drop();
    for (int i = 0; i < 7; i++) op(1, 8'(8'h10 + i), 0);
    chk("R3 err before", 16'(err), 16'h0);
    op(1, 8'hEE, 0);
    chk("R3 err", 16'(err), 16'h1);
    chk("R3 status", status, rx_st(7));
    for (int i = 0; i < 7; i++) begin
      op(0, 0, 1);
      chk("R3 contents", 16'(rd_data), 16'(8'h10 + i));
    end
    chk("R3 nothing extra", 16'(not_empty), 16'h0);
    op(1, 8'h33, 0); op(0, 0, 1);
    chk("R5 err sticky", 16'(err), 16'h1);
  endtask

  task automatic t_mid_reset();
    op(1, 8'h01, 0); op(1, 8'h02, 0);
    do_reset();
    chk("R12 status", status, rx_st(0));
    chk("R12 not_empty", 16'(not_empty), 16'h0);
    chk("R12 err", 16'(err), 16'h0);
  endtask

  task automatic t_empty_read();
    op(1, 8'h42, 0); op(0, 0, 1);
    chk("R4 setup", 16'(rd_data), 16'h42);
    op(0, 0, 1);
    chk("R4 err", 16'(err), 16'h1);
    chk("R4 data held", 16'(rd_data), 16'h42);
    chk("R4 status", status, rx_st(0));
  endtask

  task automatic t_tx_side();
    chk("R11 R10 reset", t_status, tx_st(0));
    for (int i = 0; i < 3; i++) begin
      top(1, 8'(8'h60 + i), 0);
      chk("R10 fill", t_status, tx_st(i + 1));
    end
    top(1, 8'hFF, 0);
    chk("R3 tx err", 16'(t_err), 16'h1);
    top(0, 0, 1);
    chk("R10 after read", t_status, tx_st(2));
    chk("R2 tx data", 16'(t_rdata), 16'h60);
  endtask

  task automatic t_clamp_hi();
    chk("R11 upper clamp", b_status, 16'hA000);
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset_state();
    t_clamp_hi();
    t_order();
    t_bypass();
    t_full_both();
    t_full_drop();
    t_mid_reset();
    t_empty_read();
    t_tx_side();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule